// File: doc/BRIEF.md
# Shared-Prescaler Input Debounce Filter

This block cleans up a bank of general-purpose input lines before they reach an interrupt detector. Every line first passes through a reset-cleared synchronizer. A single programmable prescaler divides the peripheral clock into a periodic sample tick, and every line uses that same tick. A line can opt in to filtering. When it does, its filtered output follows a new level only after two successive tick samples agree on that level. A line that has not opted in passes its synchronized value straight through.

A line is filtered only when two bits are set: its own debounce bit, and the interrupt-enable bit that the interrupt detector supplies for that line. Software programs the block through a simple word port that holds two registers. The first is the per-line enable mask. The second is a divisor of `DIV_WIDTH` bits, which sets the sample period in clock cycles.

As an example, a 66 MHz clock divided by 2000 gives a 33 kHz sample rate.

Top module: `gpio_debounce`

## Requirements
- R1: After reset, the enable mask reads 0, the divisor reads 0, and every filtered output is 0 while the inputs are low.
- R2: A write with `reg_addr` = 0x40 loads the enable mask, where bit i belongs to line i. A write with `reg_addr` = 0x44 loads the divisor. Reading either address returns the stored value. Any other address reads 0, and writes to it change nothing.
- R3: The divisor keeps only `reg_wdata[23:0]`. Bits 31:24 of a read at 0x44 are always 0.
- R4: For a line that is not filtered, `filt_out` shows the input exactly two clock edges after the input changes.
- R5: A line is filtered only when both its enable-mask bit and its `irq_en` bit are 1. Otherwise the line passes its input through.
- R6: With a divisor D of 2 or more, a tick occurs once every D cycles. With D equal to 0 or 1, a tick occurs on every cycle.
- R7: A write to the divisor address restarts the prescaler count from zero. If such writes arrive more often than every D cycles, no tick occurs.
- R8: On a tick, a filtered line takes the new sample as its output only if that sample equals the sample from the previous tick and differs from the present output. A pulse seen on only one tick is discarded.
- R9: When a line stops being filtered, its output switches at once to the synchronized input. Its filter history and its output are both loaded with that input, so filtering the line again does not change its output.
- R10: All filtered lines are sampled on the same shared tick, so lines that move together switch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Raw asynchronous input lines |
| irq_en | input | 32 | Per-line interrupt enable from the interrupt detector |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| filt_out | output | 32 | Filtered line levels to the interrupt detector |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both.

The first pair is a divisor write landing on the edge where the counter would also reload for a tick. A directed loop rewrites the divisor every other cycle, so a tick never arrives, and the bench confirms that a pending level change stays held until the writes stop.

The second pair is an enable or `irq_en` change landing on a tick edge. A seeded random phase toggles the enables, the interrupt enables, the divisor and the pins freely. A cycle-level model in the bench predicts `filt_out` and `reg_rdata` at every falling edge, which catches any disagreement in how the two events are ordered.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
   // Register selected by a port address
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_EN   = 2'd1,
      SEL_DIV  = 2'd2
   } reg_sel_e;

   localparam int unsigned DEF_LINES      = 32;
   localparam int unsigned DEF_DIV_WIDTH  = 24;
   localparam int unsigned DEF_ADDR_WIDTH = 8;
   localparam int unsigned DEF_DATA_WIDTH = 32;
endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < int'(STAGES); s++) pipe[s] <= '0;
            end else begin
               pipe[0] <= d;
               for (int s = 1; s < int'(STAGES); s++) pipe[s] <= pipe[s-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gdb_regs.sv
module gdb_regs
   import gdb_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 32,
   parameter int unsigned DIV_WIDTH  = 24,
   parameter int unsigned ADDR_WIDTH = 8,
   parameter int unsigned DATA_WIDTH = 32,
   parameter logic [ADDR_WIDTH-1:0] EN_OFFSET  = 'h40,
   parameter logic [ADDR_WIDTH-1:0] DIV_OFFSET = 'h44,
   parameter logic [DIV_WIDTH-1:0]  DIV_RESET  = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [ADDR_WIDTH-1:0] addr,
   input  logic [DATA_WIDTH-1:0] wdata,
   output logic [DATA_WIDTH-1:0] rdata,
   output logic [NUM_LINES-1:0]  en_q,
   output logic [DIV_WIDTH-1:0]  div_q,
   output logic                  div_wr
);
   reg_sel_e sel;

   always_comb begin
      if (addr == EN_OFFSET)       sel = SEL_EN;
      else if (addr == DIV_OFFSET) sel = SEL_DIV;
      else                         sel = SEL_NONE;
   end

   assign div_wr = we && (sel == SEL_DIV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         div_q <= DIV_RESET;
      end else if (we) begin
         if (sel == SEL_EN)  en_q  <= wdata[NUM_LINES-1:0];
         if (sel == SEL_DIV) div_q <= wdata[DIV_WIDTH-1:0];
      end
   end

   always_comb begin
      unique case (sel)
         SEL_EN:  rdata = DATA_WIDTH'(en_q);
         SEL_DIV: rdata = DATA_WIDTH'(div_q);
         default: rdata = '0;
      endcase
   end

   AST_EN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_EN) |=> en_q == $past(wdata[NUM_LINES-1:0])); // R2
   AST_STRAY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_NONE) |=> ($stable(en_q) && $stable(div_q))); // R2
   AST_DIV_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      div_wr |=> div_q == $past(wdata[DIV_WIDTH-1:0])); // R3
endmodule

// File: rtl/gdb_prescale.sv
module gdb_prescale #(
   parameter int unsigned DIV_WIDTH = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DIV_WIDTH-1:0] div,
   input  logic                 restart,
   output logic                 tick
);
   localparam logic [DIV_WIDTH-1:0] ONE = DIV_WIDTH'(1);

   logic [DIV_WIDTH-1:0] cnt_q;

   assign tick = (div <= ONE) || (cnt_q == div - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + ONE;
   end

   AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      (div > ONE) |-> (cnt_q < div)); // R6
   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/gdb_line.sv
module gdb_line (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en,
   input  logic sample,
   output logic filt
);
   logic prev_q;
   logic out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         out_q  <= 1'b0;
      end else if (!en) begin
         prev_q <= sample;
         out_q  <= sample;
      end else if (tick) begin
         prev_q <= sample;
         if ((sample == prev_q) && (sample != out_q)) out_q <= sample;
      end
   end

   assign filt = en ? out_q : sample;

   AST_QUIET_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(out_q)); // R8
   AST_NEEDS_AGREEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && (sample != prev_q)) |=> $stable(out_q)); // R8
   AST_IDLE_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ((out_q == $past(sample)) && (prev_q == $past(sample)))); // R9
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
   import gdb_pkg::*;
#(
   parameter int unsigned NUM_LINES   = DEF_LINES,
   parameter int unsigned DIV_WIDTH   = DEF_DIV_WIDTH,
   parameter int unsigned ADDR_WIDTH  = DEF_ADDR_WIDTH,
   parameter int unsigned DATA_WIDTH  = DEF_DATA_WIDTH,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [ADDR_WIDTH-1:0] EN_OFFSET  = 'h40,
   parameter logic [ADDR_WIDTH-1:0] DIV_OFFSET = 'h44,
   parameter logic [DIV_WIDTH-1:0]  DIV_RESET  = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LINES-1:0]  pin_in,
   input  logic [NUM_LINES-1:0]  irq_en,
   input  logic                  reg_we,
   input  logic [ADDR_WIDTH-1:0] reg_addr,
   input  logic [DATA_WIDTH-1:0] reg_wdata,
   output logic [DATA_WIDTH-1:0] reg_rdata,
   output logic [NUM_LINES-1:0]  filt_out
);
   generate
      if (NUM_LINES < 1 || NUM_LINES > DATA_WIDTH) begin : g_bad_lines
         $error("gpio_debounce: NUM_LINES must lie in 1..DATA_WIDTH");
      end
      if (DIV_WIDTH < 2 || DIV_WIDTH > DATA_WIDTH) begin : g_bad_div
         $error("gpio_debounce: DIV_WIDTH must lie in 2..DATA_WIDTH");
      end
      if (EN_OFFSET == DIV_OFFSET) begin : g_bad_map
         $error("gpio_debounce: register offsets must differ");
      end
   endgenerate

   logic [NUM_LINES-1:0] en_q;
   logic [DIV_WIDTH-1:0] div_q;
   logic                 div_wr;
   logic                 tick;
   logic [NUM_LINES-1:0] sync_lvl;
   logic [NUM_LINES-1:0] eff_en;

   gdb_regs #(
      .NUM_LINES (NUM_LINES),
      .DIV_WIDTH (DIV_WIDTH),
      .ADDR_WIDTH(ADDR_WIDTH),
      .DATA_WIDTH(DATA_WIDTH),
      .EN_OFFSET (EN_OFFSET),
      .DIV_OFFSET(DIV_OFFSET),
      .DIV_RESET (DIV_RESET)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .en_q  (en_q),
      .div_q (div_q),
      .div_wr(div_wr)
   );

   gdb_prescale #(.DIV_WIDTH(DIV_WIDTH)) u_prescale (
      .clk    (clk),
      .rst_n  (rst_n),
      .div    (div_q),
      .restart(div_wr),
      .tick   (tick)
   );

   gdb_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (sync_lvl)
   );

   assign eff_en = en_q & irq_en;

   generate
      for (genvar i = 0; i < int'(NUM_LINES); i++) begin : g_line
         gdb_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .en    (eff_en[i]),
            .sample(sync_lvl[i]),
            .filt  (filt_out[i])
         );
      end
   endgenerate

   AST_UNFILTERED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ((~eff_en & (filt_out ^ sync_lvl)) == '0)); // R5
endmodule

// File: tb/gpio_debounce_bench.sv
module gpio_debounce_bench;
   localparam int N  = 32;
   localparam int DW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  irq_en = '0;
   logic          reg_we = 1'b0;
   logic [7:0]    reg_addr = 8'h00;
   logic [31:0]   reg_wdata = '0;
   wire  [31:0]   reg_rdata;
   wire  [N-1:0]  filt_out;

   always #5 clk = ~clk;

   gpio_debounce u_gpio_debounce (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .irq_en   (irq_en),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .filt_out (filt_out)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Cycle model built from the requirements
   logic [N-1:0]  m_en, m_s1, m_s2, m_prev, m_out;
   logic [DW-1:0] m_div, m_cnt;
   logic          m_tick;
   logic [N-1:0]  m_eff;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_out = '0;
         m_div = '0; m_cnt = '0;
      end else begin
         m_tick = (m_div <= 1) || (m_cnt == m_div - 1);   // R6
         m_eff  = m_en & irq_en;                           // R5
         if (reg_we && reg_addr == 8'h44) m_cnt = '0;      // R7
         else if (m_tick)                 m_cnt = '0;
         else                             m_cnt = m_cnt + 1;
         for (int i = 0; i < N; i++) begin
            if (!m_eff[i]) begin                           // R9
               m_prev[i] = m_s2[i];
               m_out[i]  = m_s2[i];
            end else if (m_tick) begin                     // R8 R10
               if (m_s2[i] == m_prev[i] && m_s2[i] != m_out[i]) m_out[i] = m_s2[i];
               m_prev[i] = m_s2[i];
            end
         end
         m_s2 = m_s1;
         m_s1 = pin_in;
         if (reg_we && reg_addr == 8'h40) m_en  = reg_wdata[N-1:0];
         if (reg_we && reg_addr == 8'h44) m_div = reg_wdata[DW-1:0];
      end
   end

   function automatic logic [N-1:0] exp_filt();
      logic [N-1:0] e;
      e = m_en & irq_en;
      return (e & m_out) | (~e & m_s2);
   endfunction

   function automatic logic [31:0] exp_rdata(input logic [7:0] a);
      if (a == 8'h40) return 32'(m_en);
      if (a == 8'h44) return {8'h00, m_div};               // R3
      return 32'h0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Model comparison at every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 R5 R6 R7 R8 R10 filt_out vs model", filt_out, exp_filt());
         chk("R2 R3 reg_rdata vs model", reg_rdata, exp_rdata(reg_addr));
      end
   end

   task automatic drive_cycle();
      @(negedge clk); #1;
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      drive_cycle();
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      drive_cycle();
      reg_we = 1'b0;
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      drive_cycle();
      rst_n = 1'b1;

      // R1 reset state
      reg_addr = 8'h40;
      @(negedge clk);
      chk("R1 enable mask after reset", reg_rdata, 32'h0);
      chk("R1 filt_out after reset", 32'(filt_out), 32'h0);
      drive_cycle(); reg_addr = 8'h44;
      @(negedge clk);
      chk("R1 divisor after reset", reg_rdata, 32'h0);

      // R3 upper bits dropped; R2 stray address
      reg_write(8'h44, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R3 divisor upper bits read zero", reg_rdata, 32'h00FF_FFFF);
      reg_write(8'h48, 32'hDEAD_BEEF);
      @(negedge clk);
      chk("R2 unmapped address reads zero", reg_rdata, 32'h0);
      drive_cycle(); reg_addr = 8'h40;
      @(negedge clk);
      chk("R2 unmapped write left mask alone", reg_rdata, 32'h0);

      // R5 / R4 debounce bit set but interrupt enable low: pass-through in two edges
      reg_write(8'h40, 32'h0000_0001);
      reg_write(8'h44, 32'h1);
      drive_cycle(); pin_in[0] = 1'b1;
      @(negedge clk);
      chk("R4 not yet through after one edge", 32'(filt_out[0]), 32'h0);
      @(negedge clk);
      chk("R4 R5 through after two edges", 32'(filt_out[0]), 32'h1);

      // R8 glitch rejection with divisor 4
      drive_cycle(); irq_en[0] = 1'b1;
      reg_write(8'h44, 32'h4);
      drive_cycle(); pin_in[0] = 1'b0;
      drive_cycle(); pin_in[0] = 1'b1;
      wait_cycles(30);
      chk("R8 single-sample glitch ignored", 32'(filt_out[0]), 32'h1);
      drive_cycle(); pin_in[0] = 1'b0;
      wait_cycles(30);
      chk("R8 steady level accepted", 32'(filt_out[0]), 32'h0);

      // R7 repeated divisor writes starve the tick
      drive_cycle(); pin_in[0] = 1'b1;
      for (int k = 0; k < 20; k++) reg_write(8'h44, 32'h3);
      chk("R7 restarts hold off the tick", 32'(filt_out[0]), 32'h0);
      wait_cycles(20);
      chk("R7 level taken once writes stop", 32'(filt_out[0]), 32'h1);

      // R9 dropping the enable switches at once, re-enable keeps level
      reg_write(8'h44, 32'h1);
      reg_write(8'h40, 32'h0000_0003);
      drive_cycle(); irq_en[1] = 1'b1; pin_in[1] = 1'b1;
      wait_cycles(10);
      chk("R9 line1 settled high", 32'(filt_out[1]), 32'h1);
      drive_cycle();
      pin_in[1] = 1'b0; reg_we = 1'b1; reg_addr = 8'h40; reg_wdata = 32'h1;
      @(negedge clk);
      chk("R9 pass-through shows old sync level", 32'(filt_out[1]), 32'h1);
      #1 reg_we = 1'b0;
      @(negedge clk);
      chk("R9 follows input without filter delay", 32'(filt_out[1]), 32'h0);
      reg_write(8'h40, 32'h3);
      chk("R9 re-enable keeps level", 32'(filt_out[1]), 32'h0);
      wait_cycles(5);
      chk("R9 history reloaded", 32'(filt_out[1]), 32'h0);

      // R10 all lines share the tick
      reg_write(8'h40, 32'hFFFF_FFFF);
      drive_cycle(); irq_en = '1; pin_in = '0;
      reg_write(8'h44, 32'h3);
      wait_cycles(20);
      drive_cycle(); pin_in = '1;
      begin
         bit split = 1'b0;
         for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (filt_out != '0 && filt_out != '1) split = 1'b1;
         end
         chk("R10 lines switch in the same cycle", 32'(split), 32'h0);
         chk("R10 all lines high", 32'(filt_out), 32'hFFFF_FFFF);
      end

      // Random phase against the model
      for (int c = 0; c < 4000; c++) begin
         drive_cycle();
         reg_we = 1'b0;
         pin_in = pin_in ^ ($urandom & $urandom & $urandom & $urandom);
         if ($urandom_range(0, 31) == 0) irq_en = $urandom;
         case ($urandom_range(0, 3))
            0: reg_addr = 8'h40;
            1: reg_addr = 8'h44;
            2: reg_addr = 8'h48;
            default: reg_addr = 8'h3C;
         endcase
         if ($urandom_range(0, 15) == 0) begin
            reg_we = 1'b1;
            reg_wdata = (reg_addr == 8'h44) ? ($urandom & 32'hFF00_0007) : $urandom;
         end
      end
      drive_cycle(); reg_we = 1'b0;
      wait_cycles(2);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule